// File: doc/BRIEF.md
# Character LCD Bus Sniffer

This block sits passively on the bus between a host and a character-LCD controller that is run with a four-bit data path. It never drives the bus. It watches a register-select line, an enable strobe and four data lines, and from them it keeps a live copy of what a 4-row by 20-column text screen shows.

All bus inputs pass through a two-flop synchroniser into the system clock domain. The data lines are taken on each falling edge of the synchronised strobe, and two such nibbles, the upper one first, form a byte. A byte sent with register-select high is a character. It is stored at the position the tracked cursor points to, and the cursor then moves on by one. A byte sent with register-select low is a command. Set-address, clear and home commands move the cursor or wipe the copy.

The controller numbers its cells in four separate address runs, one per row. The sniffer turns these into linear screen positions 0 to 79, row by row. Each stored character is announced by a one-cycle pulse that carries its position and code, and any position can be read back at any time through a combinational port.

Top module: `charlcd_snoop`

## Requirements
- R1: Data lines are captured only when the synchronised strobe goes from 1 to 0. The data level while the strobe is high, or while it is held low, has no effect.
- R2: Two captured nibbles form one byte, the first in bits [7:4] and the second in bits [3:0]. Reset returns the pairing to the upper-nibble phase, so half a byte received before reset is discarded.
- R3: The register-select level captured with the second nibble classifies the byte: 1 means a character, 0 means a command. A stored character gives a one-cycle `wr_valid_o` pulse with its position and code, and from the next cycle the read port shows it at that position.
- R4: After every character byte the 7-bit cursor address goes up by one, wrapping from 0x7F to 0x00. This holds even when the character itself is dropped.
- R5: A command byte with bit 7 set loads the cursor with bits [6:0] and does not write to the screen.
- R6: Command 0x01 sets all 80 positions to 0x20 and the cursor to 0x00. Reset leaves the screen in the same all-0x20 state with no write pulse.
- R7: Command 0x02 sets the cursor to 0x00 and leaves the screen contents unchanged.
- R8: Cursor addresses map to positions as follows. 0x00–0x13 go to 0–19, 0x40–0x53 to 20–39, 0x14–0x27 to 40–59 and 0x54–0x67 to 60–79. So a cursor that runs past the end of row 0 continues in row 2.
- R9: A character whose cursor address lies outside the four ranges is dropped. It gives no pulse and changes no position.
- R10: Any other command byte (bit 7 clear and not 0x01 or 0x02) leaves the cursor and the screen unchanged.
- R11: `rd_char_o` shows, in the same cycle, the character stored at position `rd_pos_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_rs_i | input | 1 | Observed register-select line |
| lcd_stb_i | input | 1 | Observed enable strobe |
| lcd_nib_i | input | 4 | Observed upper four data lines |
| rd_pos_i | input | 7 | Screen position to read, 0 to 79 |
| rd_char_o | output | 8 | Character at `rd_pos_i` |
| wr_valid_o | output | 1 | One-cycle pulse for each stored character |
| wr_pos_o | output | 7 | Position of the stored character |
| wr_char_o | output | 8 | Code of the stored character |

## Verification
The hardest cases to reach from the ports are where the cursor walks off a row. Running off the end of row 0 must land in row 2. Running off the end of row 3 must drop characters while the cursor keeps counting, and the cursor must then wrap past 0x7F back into row 0. None of these paths is reached in a single step. The stimulus first parks the cursor near each boundary with a set-address command, then streams characters across it. An independent address model in the bench predicts each pulse, or its absence, while full read-port sweeps confirm that dropped characters left no trace. Half-byte resets and data-line movement while the strobe is high or held low are driven on purpose, to catch nibble-pairing slips.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;
    localparam int COLS     = 20;
    localparam int ROWS     = 4;
    localparam int CELLS    = COLS * ROWS;
    localparam int POS_W    = $clog2(CELLS);
    localparam int ADDR_W   = 7;
    localparam int NIB_W    = 4;
    localparam int CHAR_W   = 2 * NIB_W;
    localparam int ODD_ROW_OFS = 64;

    localparam logic [CHAR_W-1:0] SPACE_CHAR = 8'h20;
    localparam logic [CHAR_W-1:0] CMD_WIPE   = 8'h01;
    localparam logic [CHAR_W-1:0] CMD_HOME   = 8'h02;

    typedef struct packed {
        logic              vld;
        logic              rs;
        logic [CHAR_W-1:0] val;
    } lcd_byte_t;
endpackage

// File: rtl/charlcd_sync.sv
module charlcd_sync
    import charlcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_i,
    input  logic             rs_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic             fall_o,
    output logic             rs_o,
    output logic [NIB_W-1:0] nib_o
);
    localparam int BW = NIB_W + 2;

    typedef struct packed {
        logic [BW-1:0] s1;
        logic [BW-1:0] s2;
        logic          stb_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.s1       = {stb_i, rs_i, nib_i};
        d.s2       = q.s1;
        d.stb_prev = q.s2[BW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign fall_o = q.stb_prev & ~q.s2[BW-1];
    assign rs_o   = q.s2[BW-2];
    assign nib_o  = q.s2[NIB_W-1:0];
endmodule

// File: rtl/charlcd_nibpair.sv
module charlcd_nibpair
    import charlcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic             rs_i,
    input  logic [NIB_W-1:0] nib_i,
    output lcd_byte_t        byte_o
);
    typedef struct packed {
        logic             lo_phase;
        logic [NIB_W-1:0] upper;
        lcd_byte_t        out;
    } pair_t;

    pair_t q, d;

    always_comb begin
        d         = q;
        d.out.vld = 1'b0;
        if (fall_i) begin
            if (!q.lo_phase) begin
                d.upper    = nib_i;
                d.lo_phase = 1'b1;
            end else begin
                d.out.vld  = 1'b1;
                d.out.rs   = rs_i;
                d.out.val  = {q.upper, nib_i};
                d.lo_phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign byte_o = q.out;
endmodule

// File: rtl/charlcd_addrmap.sv
module charlcd_addrmap
    import charlcd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [POS_W-1:0]  pos_o
);
    logic [ROWS-1:0]  row_hit;
    logic [POS_W-1:0] row_pos [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int BASE = (r % 2) * ODD_ROW_OFS + (r / 2) * COLS;
        assign row_hit[r] = ({1'b0, addr_i} >= 8'(BASE)) &&
                            ({1'b0, addr_i} <  8'(BASE + COLS));
        assign row_pos[r] = POS_W'(addr_i) - POS_W'(BASE) + POS_W'(r * COLS);
    end

    always_comb begin
        hit_o = 1'b0;
        pos_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_hit[r]) begin
                hit_o = 1'b1;
                pos_o = row_pos[r];
            end
        end
    end
endmodule

// File: rtl/charlcd_screen.sv
module charlcd_screen
    import charlcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe_i,
    input  logic              we_i,
    input  logic [POS_W-1:0]  wpos_i,
    input  logic [CHAR_W-1:0] wchar_i,
    input  logic [POS_W-1:0]  rpos_i,
    output logic [CHAR_W-1:0] rchar_o
);
    logic [CHAR_W-1:0] cell_q [CELLS];
    logic [CHAR_W-1:0] cell_d [CELLS];

    always_comb begin
        for (int i = 0; i < CELLS; i++) begin
            if (wipe_i)                               cell_d[i] = SPACE_CHAR;
            else if (we_i && (32'(wpos_i) == i))      cell_d[i] = wchar_i;
            else                                      cell_d[i] = cell_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < CELLS; i++) begin
            if (rst) cell_q[i] <= SPACE_CHAR;
            else     cell_q[i] <= cell_d[i];
        end
    end

    always_comb begin
        rchar_o = SPACE_CHAR;
        for (int i = 0; i < CELLS; i++) begin
            if (32'(rpos_i) == i) rchar_o = cell_q[i];
        end
    end
endmodule

// File: rtl/charlcd_snoop.sv
module charlcd_snoop
    import charlcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lcd_rs_i,
    input  logic              lcd_stb_i,
    input  logic [NIB_W-1:0]  lcd_nib_i,
    input  logic [POS_W-1:0]  rd_pos_i,
    output logic [CHAR_W-1:0] rd_char_o,
    output logic              wr_valid_o,
    output logic [POS_W-1:0]  wr_pos_o,
    output logic [CHAR_W-1:0] wr_char_o
);
    logic             strobe_fall;
    logic             sync_rs;
    logic [NIB_W-1:0] sync_nib;
    lcd_byte_t        rx_byte;
    logic             map_hit;
    logic [POS_W-1:0] map_pos;
    logic             wipe;
    logic             store_we;

    typedef struct packed {
        logic [ADDR_W-1:0] cursor;
        logic              wv;
        logic [POS_W-1:0]  wpos;
        logic [CHAR_W-1:0] wchar;
    } ctl_t;

    ctl_t q, d;

    charlcd_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (lcd_stb_i),
        .rs_i   (lcd_rs_i),
        .nib_i  (lcd_nib_i),
        .fall_o (strobe_fall),
        .rs_o   (sync_rs),
        .nib_o  (sync_nib)
    );

    charlcd_nibpair u_pair (
        .clk    (clk),
        .rst    (rst),
        .fall_i (strobe_fall),
        .rs_i   (sync_rs),
        .nib_i  (sync_nib),
        .byte_o (rx_byte)
    );

    charlcd_addrmap u_map (
        .addr_i (q.cursor),
        .hit_o  (map_hit),
        .pos_o  (map_pos)
    );

    always_comb begin
        d        = q;
        d.wv     = 1'b0;
        wipe     = 1'b0;
        store_we = 1'b0;
        if (rx_byte.vld) begin
            if (rx_byte.rs) begin
                if (map_hit) begin
                    store_we = 1'b1;
                    d.wv     = 1'b1;
                    d.wpos   = map_pos;
                    d.wchar  = rx_byte.val;
                end
                d.cursor = q.cursor + 1'b1;
            end else if (rx_byte.val[CHAR_W-1]) begin
                d.cursor = rx_byte.val[ADDR_W-1:0];
            end else if (rx_byte.val == CMD_WIPE) begin
                wipe     = 1'b1;
                d.cursor = '0;
            end else if (rx_byte.val == CMD_HOME) begin
                d.cursor = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    charlcd_screen u_screen (
        .clk     (clk),
        .rst     (rst),
        .wipe_i  (wipe),
        .we_i    (store_we),
        .wpos_i  (map_pos),
        .wchar_i (rx_byte.val),
        .rpos_i  (rd_pos_i),
        .rchar_o (rd_char_o)
    );

    assign wr_valid_o = q.wv;
    assign wr_pos_o   = q.wpos;
    assign wr_char_o  = q.wchar;
endmodule

// File: rtl/charlcd_snoop_chk.sv
module charlcd_snoop_chk
    import charlcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fall,
    input lcd_byte_t         rx_byte,
    input logic              wr_valid,
    input logic [POS_W-1:0]  wr_pos,
    input logic [CHAR_W-1:0] wr_char
);
    AST_BYTE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_byte.vld |-> $past(fall)); // R1

    AST_WRITE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(rx_byte.vld && rx_byte.rs)); // R3

    AST_WRITE_CARRIES_BYTE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_char == $past(rx_byte.val))); // R2

    AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rx_byte.vld && !rx_byte.rs) |=> !wr_valid); // R5

    AST_POS_IN_SCREEN: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (32'(wr_pos) < CELLS)); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R3
endmodule

bind charlcd_snoop charlcd_snoop_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .fall     (strobe_fall),
    .rx_byte  (rx_byte),
    .wr_valid (wr_valid_o),
    .wr_pos   (wr_pos_o),
    .wr_char  (wr_char_o)
);

// File: tb/test_charlcd_snoop.sv
module test_charlcd_snoop;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lcd_rs_i = 1'b0;
    logic       lcd_stb_i = 1'b0;
    logic [3:0] lcd_nib_i = 4'h0;
    logic [6:0] rd_pos_i = 7'd0;
    logic [7:0] rd_char_o;
    logic       wr_valid_o;
    logic [6:0] wr_pos_o;
    logic [7:0] wr_char_o;

    int n_run  = 0;
    int n_fail = 0;

    logic [14:0] exp_q [$];
    logic [7:0]  m_scr [80];
    logic [6:0]  m_cur;

    always #2 clk = ~clk;

    charlcd_snoop i_charlcd_snoop (
        .clk        (clk),
        .rst        (rst),
        .lcd_rs_i   (lcd_rs_i),
        .lcd_stb_i  (lcd_stb_i),
        .lcd_nib_i  (lcd_nib_i),
        .rd_pos_i   (rd_pos_i),
        .rd_char_o  (rd_char_o),
        .wr_valid_o (wr_valid_o),
        .wr_pos_o   (wr_pos_o),
        .wr_char_o  (wr_char_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent address model (R8)
    function automatic int pos_of(input logic [6:0] a);
        if (a <= 7'h13)                  return int'(a);
        if (a >= 7'h40 && a <= 7'h53)    return int'(a) - 'h40 + 20;
        if (a >= 7'h14 && a <= 7'h27)    return int'(a) - 'h14 + 40;
        if (a >= 7'h54 && a <= 7'h67)    return int'(a) - 'h54 + 60;
        return -1;
    endfunction

    // Monitor: pops the scoreboard on every write pulse
    always @(negedge clk) begin
        if (!rst && wr_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R9", {wr_pos_o, wr_char_o}, 0, "unexpected write pulse");
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                check("R3", int'(wr_pos_o), int'(e[14:8]), "write position");
                check("R3", int'(wr_char_o), int'(e[7:0]), "write character");
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 80; i++) m_scr[i] = 8'h20;
        m_cur = 7'h00;
        exp_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lcd_stb_i = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Data lines carry a wrong value right after the rising edge (R1)
    task automatic send_nib(input logic rs, input logic [3:0] nib);
        @(negedge clk);
        lcd_rs_i  = ~rs;
        lcd_nib_i = ~nib;
        lcd_stb_i = 1'b1;
        repeat (2) @(negedge clk);
        lcd_rs_i  = rs;
        lcd_nib_i = nib;
        repeat (3) @(negedge clk);
        lcd_stb_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic rs, input logic [7:0] b);
        send_nib(rs, b[7:4]);
        send_nib(rs, b[3:0]);
        repeat (3) @(negedge clk);
    endtask

    task automatic put_char(input logic [7:0] ch);
        int p;
        p = pos_of(m_cur);
        if (p >= 0) begin
            exp_q.push_back({7'(p), ch});
            m_scr[p] = ch;
        end
        m_cur = m_cur + 7'd1;
        send_byte(1'b1, ch);
    endtask

    task automatic put_cmd(input logic [7:0] c);
        if (c[7]) m_cur = c[6:0];
        else if (c == 8'h01) begin
            for (int i = 0; i < 80; i++) m_scr[i] = 8'h20;
            m_cur = 7'h00;
        end else if (c == 8'h02) m_cur = 7'h00;
        send_byte(1'b0, c);
    endtask

    task automatic check_screen(input string req);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            rd_pos_i = 7'(i);
            #1;
            check(req, int'(rd_char_o), int'(m_scr[i]), $sformatf("read port pos %0d", i));
        end
    endtask

    task automatic check_drained(input string req);
        repeat (4) @(negedge clk);
        check(req, exp_q.size(), 0, "pending expected writes");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R6: reset state
        check("R6", int'(wr_valid_o), 0, "write pulse after reset");
        check_screen("R6");

        // R5 R8: row 1 via set-address
        put_cmd(8'hC0);
        put_char("A");
        put_char("B");
        check_drained("R5");

        // R8 R4: run off row 0 into row 2
        put_cmd(8'h92);
        put_char("x");
        put_char("y");
        put_char("z");
        check_drained("R8");
        check_screen("R8");

        // R9 R4: end of row 3, then unmapped addresses
        put_cmd(8'hE7);
        put_char("L");
        put_char("m");
        put_char("n");
        put_cmd(8'hA8);
        put_char("Z");
        check_drained("R9");
        check_screen("R9");

        // R4: cursor wraps 0x7F -> 0x00
        put_cmd(8'hFF);
        put_char("w");
        put_char("W");
        check_drained("R4");

        // R10: other command ignored
        put_cmd(8'h85);
        put_cmd(8'h0C);
        put_char("Q");
        check_drained("R10");

        // R7: home keeps content
        put_cmd(8'h02);
        put_char("H");
        check_drained("R7");
        check_screen("R7");

        // R1: data lines move while strobe stays low
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            lcd_nib_i = 4'(k * 5);
            lcd_rs_i  = k[0];
            repeat (3) @(negedge clk);
        end
        check("R1", exp_q.size(), 0, "no write from idle data movement");
        put_char("k");
        check_drained("R1");

        // R2: half byte then reset
        send_nib(1'b1, 4'h7);
        do_reset();
        put_char("J");
        check_drained("R2");
        check_screen("R2");

        // R6: wipe
        put_cmd(8'hC3);
        put_char("s");
        put_cmd(8'h01);
        put_char("C");
        check_drained("R6");
        check_screen("R6");

        // R11: read port tracks rd_pos_i in the same cycle
        @(negedge clk);
        rd_pos_i = 7'd0;
        #1;
        check("R11", int'(rd_char_o), int'("C"), "same-cycle read pos 0");
        rd_pos_i = 7'd1;
        #1;
        check("R11", int'(rd_char_o), 'h20, "same-cycle read pos 1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule